// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block keeps the burst settings that a memory controller programs into an SDRAM through a mode register set cycle. When the controller issues a read or write, the block produces the column addresses for every beat of the burst, one per clock. It marks each beat as valid and flags the final beat. It also decodes the CAS latency so that the data-path timing logic can use it.

Two column orders are supported. Sequential order counts the low column bits upward and wraps them within the burst-aligned block. Interleaved order XORs the starting column with the beat index. With sequential order, a full-page burst walks all 256 columns of the row, wrapping from 255 to 0, until it is stopped. An optional single-write setting shortens write bursts to one beat while reads keep the programmed length.

A burst ends in one of three ways: it runs to its length, a stop pulse cuts it short, or a terminate pulse cuts it short (for example when a precharge interrupts it). A new start pulse during a burst begins a fresh burst at once. A mode-set cycle that carries a reserved code is rejected with an error pulse, and the old settings are kept.

Top module: `sdram_burst_addr_gen`

## Requirements
- R1: After synchronous reset the settings are burst length 1, sequential order, CAS latency 2 and single-write off; beat_valid, last_beat and mode_err are low.
- R2: Mode bits [2:0] set the burst length: 000 = 1, 001 = 2, 010 = 4, 011 = 8 beats. The first beat is on the outputs in the cycle after the start pulse, each later beat is one cycle later, last_beat is high on the final beat only, and beat_valid drops in the cycle after the final beat.
- R3: When mode bit 3 is 0 (sequential), beat k presents the column whose low log2(N) bits are (start + k) mod N and whose upper bits equal those of the start column.
- R4: When mode bit 3 is 1 (interleave), the low log2(N) bits of beat k equal the start column's low bits XOR k, and the upper bits stay fixed.
- R5: Code 111 in bits [2:0] with bit 3 = 0 selects full page. Beat k is (start + k) mod 256, last_beat stays low, and the burst continues until it is stopped or terminated.
- R6: Mode bits [6:4] set the CAS latency: 010 gives cas_lat = 2 and 011 gives cas_lat = 3, visible in the cycle after the mode-set pulse.
- R7: A mode set with length code 100, 101 or 110, with code 111 together with bit 3 = 1, or with a latency code other than 010 or 011 raises mode_err for one cycle and leaves all previous settings in force.
- R8: When mode bit 9 is 1, a burst started as a write has exactly one beat. A burst started as a read uses the programmed length.
- R9: A burst_stop pulse with no start in the same cycle ends the burst. beat_valid is low from the next cycle.
- R10: A terminate pulse with no start in the same cycle ends the burst in the same way as burst_stop.
- R11: A start pulse during a burst takes priority over stop and terminate. It restarts from the new column with the current settings.
- R12: A mode set during a burst does not change the length or order of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_set | input | 1 | Mode register set strobe |
| mode_addr | input | 12 | Address bus value during mode set |
| start | input | 1 | Read/write command pulse starting a burst |
| start_col | input | 8 | Starting column of the burst |
| start_is_write | input | 1 | 1 when the starting command is a write |
| burst_stop | input | 1 | Burst-stop command pulse |
| terminate | input | 1 | Interrupting-command pulse ending the burst |
| col_addr | output | 8 | Column of the current beat |
| beat_valid | output | 1 | A beat is presented on col_addr |
| last_beat | output | 1 | Current beat is the final one |
| cas_lat | output | 2 | Decoded CAS latency (2 or 3) |
| mode_err | output | 1 | One-cycle pulse after a rejected mode set |

## Verification
All outputs are registered. The first beat, a new CAS latency and mode_err therefore all appear exactly one clock after the input pulse that causes them. Each later beat advances one clock at a time, and a stop or terminate clears beat_valid one clock after it is sampled. The bench drives inputs on the falling edge and samples each result on the falling edge that follows the rising edge where it is due. It compares every beat's column against a model function that depends only on the start column, the length, the order and the beat index.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } col_order_e;

  // Encodings of the mode fields
  localparam logic [2:0] LEN_CODE_1    = 3'b000;
  localparam logic [2:0] LEN_CODE_2    = 3'b001;
  localparam logic [2:0] LEN_CODE_4    = 3'b010;
  localparam logic [2:0] LEN_CODE_8    = 3'b011;
  localparam logic [2:0] LEN_CODE_PAGE = 3'b111;
  localparam logic [2:0] LAT_CODE_2    = 3'b010;
  localparam logic [2:0] LAT_CODE_3    = 3'b011;
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import sdram_burst_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 8,
  parameter int LEN_LSB = 0,
  parameter int ORD_BIT = 3,
  parameter int LAT_LSB = 4,
  parameter int WR1_BIT = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_set,
  input  logic [ADDR_W-1:0] mode_addr,
  output logic [COL_W-1:0]  len_mask,
  output logic              full_page,
  output col_order_e        order,
  output logic [1:0]        cas_lat,
  output logic              wr_single,
  output logic              mode_err
);
  localparam logic [COL_W-1:0] MASK_1 = '0;
  localparam logic [COL_W-1:0] MASK_2 = COL_W'(1);
  localparam logic [COL_W-1:0] MASK_4 = COL_W'(3);
  localparam logic [COL_W-1:0] MASK_8 = COL_W'(7);
  localparam logic [COL_W-1:0] MASK_P = '1;

  logic [2:0]       len_code, lat_code;
  logic             ord_bit;
  logic             len_ok, lat_ok;
  logic [COL_W-1:0] new_mask;
  logic             new_full;
  logic [1:0]       new_lat;

  assign len_code = mode_addr[LEN_LSB +: 3];
  assign lat_code = mode_addr[LAT_LSB +: 3];
  assign ord_bit  = mode_addr[ORD_BIT];

  always_comb begin
    len_ok   = 1'b1;
    new_full = 1'b0;
    new_mask = MASK_1;
    case (len_code)
      LEN_CODE_1: new_mask = MASK_1;
      LEN_CODE_2: new_mask = MASK_2;
      LEN_CODE_4: new_mask = MASK_4;
      LEN_CODE_8: new_mask = MASK_8;
      LEN_CODE_PAGE: begin
        new_mask = MASK_P;
        new_full = 1'b1;
        len_ok   = ~ord_bit;
      end
      default: len_ok = 1'b0;
    endcase
  end

  always_comb begin
    lat_ok  = 1'b1;
    new_lat = 2'd2;
    case (lat_code)
      LAT_CODE_2: new_lat = 2'd2;
      LAT_CODE_3: new_lat = 2'd3;
      default:    lat_ok  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_mask  <= MASK_1;
      full_page <= 1'b0;
      order     <= ORD_SEQ;
      cas_lat   <= 2'd2;
      wr_single <= 1'b0;
      mode_err  <= 1'b0;
    end else begin
      mode_err <= 1'b0;
      if (mode_set) begin
        if (len_ok && lat_ok) begin
          len_mask  <= new_mask;
          full_page <= new_full;
          order     <= col_order_e'(ord_bit);
          cas_lat   <= new_lat;
          wr_single <= mode_addr[WR1_BIT];
        end else begin
          mode_err <= 1'b1;
        end
      end
    end
  end

  // R7
  keep_on_err_chk: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> ($stable(cas_lat) && $stable(len_mask) && $stable(order)));
  // R6
  cas_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (cas_lat == 2'd2) || (cas_lat == 2'd3));
  // R5
  page_seq_only_chk: assert property (@(posedge clk) disable iff (rst)
    full_page |-> (order == ORD_SEQ));
endmodule

// File: rtl/burst_col_order.sv
module burst_col_order
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] mask,
  input  col_order_e       order,
  input  logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] seq_sum;
  assign seq_sum = base + idx;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    logic moving;
    assign moving = (order == ORD_XOR) ? (base[i] ^ idx[i]) : seq_sum[i];
    assign col[i] = mask[i] ? moving : base[i];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_is_write,
  input  logic             burst_stop,
  input  logic             terminate,
  input  logic [COL_W-1:0] len_mask,
  input  logic             full_page,
  input  col_order_e       order,
  input  logic             wr_single,
  output logic [COL_W-1:0] col_addr,
  output logic             beat_valid,
  output logic             last_beat
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             act_q, last_q, full_q;
  logic [COL_W-1:0] idx_q, base_q, mask_q, col_q;
  col_order_e       ord_q;

  logic             one_beat;
  logic [COL_W-1:0] eff_mask, nxt_idx, nxt_col;

  assign one_beat = start_is_write & wr_single;
  assign eff_mask = one_beat ? '0 : len_mask;
  assign nxt_idx  = idx_q + ONE;

  burst_col_order #(.COL_W(COL_W)) u_order (
    .base  (base_q),
    .mask  (mask_q),
    .order (ord_q),
    .idx   (nxt_idx),
    .col   (nxt_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      last_q <= 1'b0;
      full_q <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
      col_q  <= '0;
      ord_q  <= ORD_SEQ;
    end else if (start) begin
      act_q  <= 1'b1;
      idx_q  <= '0;
      base_q <= start_col;
      col_q  <= start_col;
      mask_q <= eff_mask;
      ord_q  <= order;
      full_q <= full_page & ~one_beat;
      last_q <= (eff_mask == '0);
    end else if (burst_stop || terminate) begin
      act_q  <= 1'b0;
      last_q <= 1'b0;
    end else if (act_q) begin
      if (last_q) begin
        act_q  <= 1'b0;
        last_q <= 1'b0;
      end else begin
        idx_q  <= nxt_idx;
        col_q  <= nxt_col;
        last_q <= ~full_q & (nxt_idx == mask_q);
      end
    end
  end

  assign col_addr   = col_q;
  assign beat_valid = act_q;
  assign last_beat  = last_q;

  // R2
  last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> beat_valid);
  // R2
  end_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (last_beat && !start) |=> !beat_valid);
  // R9
  stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
    ((burst_stop || terminate) && !start) |=> !beat_valid);
  // R11
  start_loads_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (beat_valid && col_addr == $past(start_col)));
  // R5
  page_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && full_q && ord_q == ORD_SEQ && !start && !burst_stop && !terminate)
      |=> (beat_valid && !last_beat && col_addr == $past(col_addr) + ONE));
endmodule

// File: rtl/sdram_burst_addr_gen.sv
module sdram_burst_addr_gen
  import sdram_burst_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_set,
  input  logic [ADDR_W-1:0] mode_addr,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              start_is_write,
  input  logic              burst_stop,
  input  logic              terminate,
  output logic [COL_W-1:0]  col_addr,
  output logic              beat_valid,
  output logic              last_beat,
  output logic [1:0]        cas_lat,
  output logic              mode_err
);
  logic [COL_W-1:0] len_mask;
  logic             full_page, wr_single;
  col_order_e       order;

  burst_mode_reg #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .mode_set  (mode_set),
    .mode_addr (mode_addr),
    .len_mask  (len_mask),
    .full_page (full_page),
    .order     (order),
    .cas_lat   (cas_lat),
    .wr_single (wr_single),
    .mode_err  (mode_err)
  );

  burst_col_seq #(.COL_W(COL_W)) u_seq (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .start_col      (start_col),
    .start_is_write (start_is_write),
    .burst_stop     (burst_stop),
    .terminate      (terminate),
    .len_mask       (len_mask),
    .full_page      (full_page),
    .order          (order),
    .wr_single      (wr_single),
    .col_addr       (col_addr),
    .beat_valid     (beat_valid),
    .last_beat      (last_beat)
  );
endmodule

// File: tb/sdram_burst_addr_gen_bench.sv
`timescale 1ns/1ps
module sdram_burst_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        mode_set;
  logic [11:0] mode_addr;
  logic        start;
  logic [7:0]  start_col;
  logic        start_is_write;
  logic        burst_stop;
  logic        terminate;
  logic [7:0]  col_addr;
  logic        beat_valid;
  logic        last_beat;
  logic [1:0]  cas_lat;
  logic        mode_err;

  always #2.5 clk = ~clk;

  sdram_burst_addr_gen u_sdram_burst_addr_gen (
    .clk(clk), .rst(rst), .mode_set(mode_set), .mode_addr(mode_addr),
    .start(start), .start_col(start_col), .start_is_write(start_is_write),
    .burst_stop(burst_stop), .terminate(terminate), .col_addr(col_addr),
    .beat_valid(beat_valid), .last_beat(last_beat), .cas_lat(cas_lat),
    .mode_err(mode_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model of the settings
  int m_len = 1;   // 256 = full page
  bit m_il  = 0;
  int m_lat = 2;
  bit m_ws  = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_col(logic [7:0] base, int n, bit il, int k);
    logic [7:0] m;
    logic [7:0] kk;
    kk = 8'(k);
    if (n >= 256) return base + kk;
    m = 8'(n - 1);
    return (base & ~m) | ((il ? (base ^ kk) : (base + kk)) & m);
  endfunction

  function automatic int len_of(logic [2:0] code);
    case (code)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 256;
      default: return 0;
    endcase
  endfunction

  task automatic idle_inputs();
    mode_set = 0; mode_addr = '0; start = 0; start_col = '0;
    start_is_write = 0; burst_stop = 0; terminate = 0;
  endtask

  // drive a mode set; check mode_err and cas_lat one cycle later
  task automatic set_mode(logic [2:0] lc, bit bt, logic [2:0] cc, bit ws, string req);
    bit bad;
    bad = (len_of(lc) == 0) || (lc == 3'b111 && bt) || !(cc == 3'b010 || cc == 3'b011);
    @(negedge clk);
    mode_set  = 1;
    mode_addr = {2'b00, ws, 2'b00, cc, bt, lc};
    @(negedge clk);
    mode_set  = 0;
    mode_addr = '0;
    if (!bad) begin
      m_len = len_of(lc); m_il = bt; m_lat = (cc == 3'b011) ? 3 : 2; m_ws = ws;
    end
    chk(mode_err == bad, {req, " mode_err"}, int'(mode_err), int'(bad));
    chk(int'(cas_lat) == m_lat, {req, " cas_lat"}, int'(cas_lat), m_lat);
  endtask

  task automatic check_beat(logic [7:0] ecol, bit elast, string req);
    chk(beat_valid == 1'b1, {req, " valid"}, int'(beat_valid), 1);
    chk(col_addr == ecol, {req, " col"}, int'(col_addr), int'(ecol));
    chk(last_beat == elast, {req, " last"}, int'(last_beat), int'(elast));
  endtask

  // full burst; full-page bursts are stopped after page_beats beats
  task automatic run_burst(logic [7:0] col, bit wr, int page_beats, string req);
    int n;
    bit full;
    n    = (wr && m_ws) ? 1 : m_len;
    full = (n == 256);
    if (full) n = page_beats;
    @(negedge clk);
    start = 1; start_col = col; start_is_write = wr;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      check_beat(exp_col(col, full ? 256 : n, m_il, k), !full && (k == n - 1), req);
    end
    if (full) burst_stop = 1;
    @(negedge clk);
    burst_stop = 0;
    chk(beat_valid == 1'b0, {req, " ends"}, int'(beat_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5D2A_0711));
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(beat_valid == 0, "R1 valid", int'(beat_valid), 0);
    chk(last_beat == 0, "R1 last", int'(last_beat), 0);
    chk(cas_lat == 2'd2, "R1 cas_lat", int'(cas_lat), 2);
    chk(mode_err == 0, "R1 mode_err", int'(mode_err), 0);
    run_burst(8'h37, 1'b0, 0, "R1 default length");
    run_burst(8'h38, 1'b1, 0, "R1 single-write off");

    // R2 R3 R4 R6 every length in both orders
    for (int lc = 0; lc < 4; lc++) begin
      set_mode(3'(lc), 1'b0, 3'b011, 1'b0, "R6 lat3");
      run_burst(8'hAD, 1'b0, 0, "R2 R3 seq");
      set_mode(3'(lc), 1'b1, 3'b010, 1'b0, "R6 lat2");
      run_burst(8'hAD, 1'b1, 0, "R2 R4 xor");
    end

    // R7 reserved codes keep the settings (length 8 xor, lat 2 now)
    set_mode(3'b100, 1'b0, 3'b011, 1'b0, "R7 len100");
    set_mode(3'b111, 1'b1, 3'b011, 1'b0, "R7 page+xor");
    set_mode(3'b001, 1'b0, 3'b001, 1'b0, "R7 lat001");
    set_mode(3'b010, 1'b0, 3'b100, 1'b0, "R7 lat100");
    run_burst(8'h5B, 1'b0, 0, "R7 kept length/order");

    // R5 full page wrap
    set_mode(3'b111, 1'b0, 3'b011, 1'b0, "R5 set");
    run_burst(8'hFA, 1'b0, 12, "R5 wrap");

    // R8 single write
    set_mode(3'b010, 1'b0, 3'b010, 1'b1, "R8 set");
    run_burst(8'h21, 1'b1, 0, "R8 write one beat");
    run_burst(8'h21, 1'b0, 0, "R8 read full length");

    // R10 terminate mid-burst (length 8)
    set_mode(3'b011, 1'b0, 3'b010, 1'b0, "R10 set");
    @(negedge clk);
    start = 1; start_col = 8'h43; start_is_write = 0;
    @(negedge clk); start = 0;
    check_beat(8'h43, 0, "R10 b0");
    @(negedge clk);
    check_beat(8'h44, 0, "R10 b1");
    terminate = 1;
    @(negedge clk); terminate = 0;
    chk(beat_valid == 0, "R10 ended", int'(beat_valid), 0);
    @(negedge clk);
    chk(beat_valid == 0, "R10 stays idle", int'(beat_valid), 0);

    // R9 stop in a length-8 burst
    @(negedge clk);
    start = 1; start_col = 8'h07;
    @(negedge clk); start = 0;
    check_beat(8'h07, 0, "R9 b0");
    burst_stop = 1;
    @(negedge clk); burst_stop = 0;
    chk(beat_valid == 0, "R9 ended", int'(beat_valid), 0);

    // R11 restart with stop in the same cycle, R12 mode set mid-burst
    @(negedge clk);
    start = 1; start_col = 8'h90;
    @(negedge clk); start = 0;
    check_beat(8'h90, 0, "R11 b0");
    @(negedge clk);
    check_beat(8'h91, 0, "R11 b1");
    start = 1; start_col = 8'h1E; burst_stop = 1;
    mode_set = 1; mode_addr = {5'b0, 3'b010, 1'b1, 3'b001};
    @(negedge clk);
    start = 0; burst_stop = 0; mode_set = 0; mode_addr = '0;
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(negedge clk);
      check_beat(exp_col(8'h1E, 8, 1'b0, k), k == 7, "R11 R12 restart keeps length 8");
    end
    m_len = 2; m_il = 1; m_lat = 2; m_ws = 0;
    @(negedge clk);
    chk(beat_valid == 0, "R12 ends", int'(beat_valid), 0);
    run_burst(8'h1E, 1'b0, 0, "R12 new setting on next start");

    // random mix
    for (int it = 0; it < 80; it++) begin
      int r;
      logic [2:0] lc;
      bit bt;
      r  = int'($urandom_range(0, 4));
      lc = (r == 4) ? 3'b111 : 3'(r);
      bt = (r == 4) ? 1'b0 : 1'($urandom_range(0, 1));
      set_mode(lc, bt, $urandom_range(0, 1) ? 3'b011 : 3'b010, 1'($urandom_range(0, 1)),
               "R2 R3 R4 R6 random");
      run_burst(8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
                int'($urandom_range(1, 20)), "R3 R4 R5 R8 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule